// File: doc/BRIEF.md
# I2C Target Address Matcher

This unit decides, for an I2C target, whether the address phase that follows a START is aimed at it. A shift register elsewhere assembles bytes from the wire and presents each finished address byte with a one-cycle valid pulse, and bus-condition detectors supply one-cycle START and STOP pulses. The unit compares the first byte after START, and in 10-bit mode also the byte after it, against a programmed own address. On a hit it pulses a match strobe together with the transfer direction, so that the acknowledge logic can respond.

Configuration has three fields: a right-justified 10-bit own address, a general-call enable and a 7-bit/10-bit mode select. Software can change them only while it holds the unit's software-reset input high. The unit also keeps two status bits. One is a sticky flag that records a general call accepted since the last START. The other shows whether the bus is busy.

Top module: `i2c_own_addr_match`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the configuration readback is all zero (address 0, general call off, 7-bit mode), and match, gc_rcvd and bus_busy are 0.
- R2: In 7-bit mode, the first address byte after START matches when byte bits 7..1 equal own-address bits 6..0. Address bits 9..7 play no part. A 7-bit own value of zero never gives an own-address match. match is high for exactly the cycle after the byte's valid cycle, and match_rw then equals byte bit 0.
- R3: In 10-bit mode, the first byte must be 5'b11110 followed by own-address bits 9..8 and the R/W bit. The next byte must equal own-address bits 7..0. Only then is match pulsed, in the cycle after the second byte, with match_rw taken from bit 0 of the first byte. No strobe follows the first byte alone.
- R4: A first address byte of 8'h00 is a general call. With general-call enable set, it pulses match (match_rw 0) and sets gc_rcvd in the same cycle, in either mode. With the enable clear, neither happens.
- R5: gc_rcvd stays set through data bytes and STOP until the next START, and reads 0 in the cycle after a START.
- R6: A configuration write takes effect only when soft_rst is 1 in the same cycle. Otherwise it is dropped, and both the readback and the matching behaviour stay unchanged.
- R7: bus_busy reads 1 in the cycle after START and 0 in the cycle after STOP. A repeated START leaves it at 1.
- R8: Only the address byte or bytes directly after a START are compared. Bytes while the bus is idle, data bytes after a hit, and bytes after a missed address never pulse match, and match never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Software reset bit; configuration writes are accepted only while it is 1 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_own_addr | input | 10 | Own address to write, right-justified |
| cfg_gc_en | input | 1 | General-call enable to write |
| cfg_ten_bit | input | 1 | Mode to write: 1 = 10-bit, 0 = 7-bit |
| rd_own_addr | output | 10 | Current own address |
| rd_gc_en | output | 1 | Current general-call enable |
| rd_ten_bit | output | 1 | Current mode |
| bus_start | input | 1 | One-cycle pulse: START or repeated START seen |
| bus_stop | input | 1 | One-cycle pulse: STOP seen |
| addr_valid | input | 1 | One-cycle pulse: addr_byte holds a completed byte |
| addr_byte | input | 8 | Received byte, R/W in bit 0 for address bytes |
| match | output | 1 | One-cycle address-match strobe |
| match_rw | output | 1 | Direction bit belonging to the last match |
| gc_rcvd | output | 1 | Sticky general-call-received flag |
| bus_busy | output | 1 | Bus activity status |

## Verification
Some rules are checked on every cycle by the assertions. Configuration is frozen whenever the software-reset input is low. START and STOP move the busy bit and clear the general-call flag. The flag only rises when the enable was set, and the match strobe never lasts two cycles and always follows a byte. Other behaviour can only be shown by the bench's scenarios. These are the address arithmetic, that is, which byte values hit for a given own address in each mode, the ignored upper bits in 7-bit mode, the two-byte 10-bit sequence, and the direction bit. They also include the dropped write that leaves matching unchanged, and the bytes that come outside the address phase. The bench covers these by sweeping every byte value against several own addresses.

// File: rtl/i2c_oam_pkg.sv
// Shared constants and types for the I2C own-address match unit.
// Assumes the 10-bit addressing format of the bus: a 5-bit header
// followed by the two top address bits in the first byte.
package i2c_oam_pkg;
    localparam int OWN_W   = 10;
    localparam int SHORT_W = 7;
    localparam int BYTE_W  = 8;
    localparam int HEAD_W  = 5;
    localparam int HI_W    = OWN_W - BYTE_W;
    localparam logic [HEAD_W-1:0] LONG_HEAD = 5'b11110;

    typedef struct packed {
        logic              ten_bit;
        logic              gc_en;
        logic [OWN_W-1:0]  own;
    } oam_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_TAIL,
        PH_HIT,
        PH_MISS
    } oam_phase_t;
endpackage

// File: rtl/oam_cfg_regs.sv
// Configuration holding register for the match unit.
// Assumes writes are single-cycle strobes; a write lands only while the
// software-reset input is high, otherwise it is dropped.
module oam_cfg_regs
    import i2c_oam_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_rst,
    input  logic     wr_en,
    input  oam_cfg_t wdata,
    output oam_cfg_t cfg
);
    // Capture configuration when unlocked by the software reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_en && soft_rst)
            cfg <= wdata;
    end

    // R6: configuration never moves while the software reset is low.
    a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(cfg));
endmodule

// File: rtl/oam_addr_compare.sv
// Combinational comparison of one received byte against the own address.
// Produces independent hit terms; the sequencer decides which one counts
// based on mode and position in the address phase.
module oam_addr_compare
    import i2c_oam_pkg::*;
(
    input  logic [OWN_W-1:0]  own,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              is_gc,
    output logic              short_hit,
    output logic              head_hit,
    output logic              tail_hit
);
    logic [SHORT_W-1:0] short_eq;

    // Per-bit equality of the 7-bit address field against byte bits 7..1.
    for (genvar i = 0; i < SHORT_W; i++) begin : g_short_eq
        assign short_eq[i] = byte_in[i+1] ~^ own[i];
    end

    // Decode the four hit terms from the byte.
    always_comb begin
        is_gc     = (byte_in == '0);
        short_hit = (&short_eq) && (|own[SHORT_W-1:0]);
        head_hit  = (byte_in[BYTE_W-1 -: HEAD_W] == LONG_HEAD) &&
                    (byte_in[HI_W:1] == own[OWN_W-1:BYTE_W]);
        tail_hit  = (byte_in == own[BYTE_W-1:0]);
    end
endmodule

// File: rtl/oam_bus_track.sv
// Bus activity tracker: busy from START until STOP.
// Assumes START and STOP arrive as one-cycle pulses; START wins a tie.
module oam_bus_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic busy
);
    // Hold the busy state between bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (start)
            busy <= 1'b1;
        else if (stop)
            busy <= 1'b0;
    end

    // R7: START marks the bus busy on the next cycle.
    a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R7: a lone STOP frees the bus on the next cycle.
    a_r7_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !busy);
endmodule

// File: rtl/oam_sequencer.sv
// Address-phase sequencer: walks head/tail byte positions after START,
// issues the match strobe and keeps the sticky general-call flag.
// Assumes one byte per addr_valid pulse and that compare terms belong to
// the byte presented in the same cycle.
module oam_sequencer
    import i2c_oam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic byte_valid,
    input  logic rw_bit,
    input  logic ten_bit,
    input  logic gc_en,
    input  logic is_gc,
    input  logic short_hit,
    input  logic head_hit,
    input  logic tail_hit,
    output logic match,
    output logic match_rw,
    output logic gc_flag
);
    oam_phase_t phase;
    logic       rw_hold;

    // Advance the address phase and produce strobe, direction and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            match    <= 1'b0;
            match_rw <= 1'b0;
            rw_hold  <= 1'b0;
            gc_flag  <= 1'b0;
        end else begin
            match <= 1'b0;
            if (start) begin
                phase   <= PH_HEAD;
                gc_flag <= 1'b0;
            end else if (stop) begin
                phase <= PH_IDLE;
            end else if (byte_valid) begin
                case (phase)
                    PH_HEAD: begin
                        if (gc_en && is_gc) begin
                            match    <= 1'b1;
                            match_rw <= 1'b0;
                            gc_flag  <= 1'b1;
                            phase    <= PH_HIT;
                        end else if (!ten_bit && short_hit) begin
                            match    <= 1'b1;
                            match_rw <= rw_bit;
                            phase    <= PH_HIT;
                        end else if (ten_bit && head_hit) begin
                            rw_hold <= rw_bit;
                            phase   <= PH_TAIL;
                        end else begin
                            phase <= PH_MISS;
                        end
                    end
                    PH_TAIL: begin
                        if (tail_hit) begin
                            match    <= 1'b1;
                            match_rw <= rw_hold;
                            phase    <= PH_HIT;
                        end else begin
                            phase <= PH_MISS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: START clears the general-call flag by the next cycle.
    a_r5_gc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !gc_flag);
    // R5: without START the flag, once set, stays set.
    a_r5_gc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (gc_flag && !start) |=> gc_flag);
    // R4: the flag only rises when general call was enabled.
    a_r4_gc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_flag) |-> $past(gc_en));
    // R8: the strobe lasts a single cycle.
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
    // R8: every strobe is caused by a byte in the previous cycle.
    a_r8_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(byte_valid));
endmodule

// File: rtl/i2c_own_addr_match.sv
// Top of the I2C own-address match unit. Joins the configuration register,
// byte comparator, address-phase sequencer and bus tracker.
// Assumes bus conditions and bytes are already decoded into pulses.
module i2c_own_addr_match
    import i2c_oam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_wr,
    input  logic [OWN_W-1:0]  cfg_own_addr,
    input  logic              cfg_gc_en,
    input  logic              cfg_ten_bit,
    output logic [OWN_W-1:0]  rd_own_addr,
    output logic              rd_gc_en,
    output logic              rd_ten_bit,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              addr_valid,
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              match,
    output logic              match_rw,
    output logic              gc_rcvd,
    output logic              bus_busy
);
    oam_cfg_t cfg_in;
    oam_cfg_t cfg;
    logic     is_gc;
    logic     short_hit;
    logic     head_hit;
    logic     tail_hit;

    // Pack write fields and unpack the stored configuration.
    always_comb begin
        cfg_in.ten_bit = cfg_ten_bit;
        cfg_in.gc_en   = cfg_gc_en;
        cfg_in.own     = cfg_own_addr;
        rd_own_addr    = cfg.own;
        rd_gc_en       = cfg.gc_en;
        rd_ten_bit     = cfg.ten_bit;
    end

    oam_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (cfg_wr),
        .wdata    (cfg_in),
        .cfg      (cfg)
    );

    oam_addr_compare u_cmp (
        .own       (cfg.own),
        .byte_in   (addr_byte),
        .is_gc     (is_gc),
        .short_hit (short_hit),
        .head_hit  (head_hit),
        .tail_hit  (tail_hit)
    );

    oam_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (bus_start),
        .stop       (bus_stop),
        .byte_valid (addr_valid),
        .rw_bit     (addr_byte[0]),
        .ten_bit    (cfg.ten_bit),
        .gc_en      (cfg.gc_en),
        .is_gc      (is_gc),
        .short_hit  (short_hit),
        .head_hit   (head_hit),
        .tail_hit   (tail_hit),
        .match      (match),
        .match_rw   (match_rw),
        .gc_flag    (gc_rcvd)
    );

    oam_bus_track u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bus_start),
        .stop  (bus_stop),
        .busy  (bus_busy)
    );
endmodule

// File: tb/test_i2c_own_addr_match.sv
`timescale 1ns/1ps
module test_i2c_own_addr_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [9:0] cfg_own_addr = '0;
    logic       cfg_gc_en = 1'b0;
    logic       cfg_ten_bit = 1'b0;
    logic [9:0] rd_own_addr;
    logic       rd_gc_en;
    logic       rd_ten_bit;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = '0;
    logic       match;
    logic       match_rw;
    logic       gc_rcvd;
    logic       bus_busy;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    i2c_own_addr_match i_i2c_own_addr_match (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
        .cfg_own_addr(cfg_own_addr), .cfg_gc_en(cfg_gc_en), .cfg_ten_bit(cfg_ten_bit),
        .rd_own_addr(rd_own_addr), .rd_gc_en(rd_gc_en), .rd_ten_bit(rd_ten_bit),
        .bus_start(bus_start), .bus_stop(bus_stop), .addr_valid(addr_valid),
        .addr_byte(addr_byte), .match(match), .match_rw(match_rw),
        .gc_rcvd(gc_rcvd), .bus_busy(bus_busy)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) begin addr_valid = 1'b1; addr_byte = b; end
        @(negedge clk) addr_valid = 1'b0;
    endtask

    task automatic write_cfg(input logic [9:0] own, input logic gc, input logic ten, input logic sr);
        @(negedge clk) begin
            soft_rst = sr; cfg_wr = 1'b1;
            cfg_own_addr = own; cfg_gc_en = gc; cfg_ten_bit = ten;
        end
        @(negedge clk) begin cfg_wr = 1'b0; soft_rst = 1'b0; end
    endtask

    // R2/R4: every first byte against a 7-bit own address.
    task automatic sweep_short(input logic [9:0] own, input logic gc);
        write_cfg(own, gc, 1'b0, 1'b1);
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            logic       exp_m;
            logic       exp_gc;
            bb = 8'(b);
            exp_gc = (bb == 8'h00) && gc;
            exp_m = ((bb[7:1] == own[6:0]) && (own[6:0] != 7'd0)) || exp_gc;
            pulse_start();
            send_byte(bb);
            if (bb == 8'h00) check_eq("R4", "gc strobe 7-bit", match, exp_m);
            else             check_eq("R2", "7-bit strobe", match, exp_m);
            if (exp_m && !exp_gc) check_eq("R2", "7-bit rw", match_rw, bb[0]);
            check_eq("R4", "gc flag 7-bit", gc_rcvd, exp_gc);
            pulse_stop();
        end
    endtask

    // R3/R4: every first byte, then every second byte, in 10-bit mode.
    task automatic sweep_long(input logic [9:0] own, input logic gc);
        logic [7:0] head;
        head = {5'b11110, own[9:8], 1'b0};
        write_cfg(own, gc, 1'b1, 1'b1);
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            logic       exp1;
            logic       exp2;
            bb = 8'(b);
            exp1 = (bb == 8'h00) && gc;
            exp2 = !exp1 && (bb[7:1] == head[7:1]);
            pulse_start();
            send_byte(bb);
            if (bb == 8'h00) check_eq("R4", "gc strobe 10-bit", match, exp1);
            else             check_eq("R3", "no strobe after head", match, 0);
            send_byte(own[7:0]);
            check_eq("R3", "strobe after tail", match, exp2);
            if (exp2) check_eq("R3", "rw from head", match_rw, bb[0]);
            pulse_stop();
        end
        for (int s = 0; s < 256; s++) begin
            logic [7:0] ss;
            ss = 8'(s);
            pulse_start();
            send_byte(head | 8'h01);
            check_eq("R3", "head alone", match, 0);
            send_byte(ss);
            check_eq("R3", "tail compare", match, ss == own[7:0]);
            if (ss == own[7:0]) check_eq("R3", "rw read", match_rw, 1);
            pulse_stop();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R8 watchdog: cycles=%0d expected below %0d", 200000, 200000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "own addr", rd_own_addr, 0);
        check_eq("R1", "gc en", rd_gc_en, 0);
        check_eq("R1", "ten bit", rd_ten_bit, 0);
        check_eq("R1", "match", match, 0);
        check_eq("R1", "gc flag", gc_rcvd, 0);
        check_eq("R1", "busy", bus_busy, 0);

        // R6: locked write is dropped, unlocked write lands
        write_cfg(10'h155, 1'b1, 1'b1, 1'b0);
        check_eq("R6", "locked own", rd_own_addr, 0);
        check_eq("R6", "locked ten", rd_ten_bit, 0);
        write_cfg(10'h155, 1'b1, 1'b1, 1'b1);
        check_eq("R6", "unlocked own", rd_own_addr, 10'h155);
        check_eq("R6", "unlocked ten", rd_ten_bit, 1);

        sweep_short(10'h3A5, 1'b1);
        sweep_short(10'h07F, 1'b0);
        sweep_short(10'h000, 1'b0);
        sweep_long(10'h2C7, 1'b1);
        sweep_long(10'h13C, 1'b0);

        // R5/R7/R8 scenario with 7-bit own 0x25 (byte 0x4A) and gc on
        write_cfg(10'h3A5, 1'b1, 1'b0, 1'b1);
        pulse_start();
        check_eq("R7", "busy after start", bus_busy, 1);
        send_byte(8'h00);
        check_eq("R4", "gc match", match, 1);
        check_eq("R5", "gc flag set", gc_rcvd, 1);
        send_byte(8'h4A);
        check_eq("R8", "data byte no strobe", match, 0);
        check_eq("R5", "flag over data", gc_rcvd, 1);
        pulse_stop();
        check_eq("R5", "flag over stop", gc_rcvd, 1);
        check_eq("R7", "idle after stop", bus_busy, 0);
        send_byte(8'h4A);
        check_eq("R8", "idle byte no strobe", match, 0);
        pulse_start();
        check_eq("R5", "flag cleared by start", gc_rcvd, 0);
        send_byte(8'h4A);
        check_eq("R2", "own match", match, 1);
        check_eq("R2", "own rw", match_rw, 0);
        pulse_start();
        check_eq("R7", "busy over repeated start", bus_busy, 1);
        send_byte(8'h4B);
        check_eq("R2", "match after repeated start", match, 1);
        check_eq("R2", "read rw", match_rw, 1);

        // R6: locked attempt to disable gc is dropped; gc still answered
        write_cfg(10'h3A5, 1'b0, 1'b0, 1'b0);
        check_eq("R6", "gc en kept", rd_gc_en, 1);
        pulse_start();
        send_byte(8'h00);
        check_eq("R6", "gc still answered", match, 1);
        // R4: unlocked disable stops the response
        write_cfg(10'h3A5, 1'b0, 1'b0, 1'b1);
        pulse_start();
        send_byte(8'h00);
        check_eq("R4", "gc disabled strobe", match, 0);
        check_eq("R4", "gc disabled flag", gc_rcvd, 0);
        // R8: byte after a miss never matches
        pulse_start();
        send_byte(8'h10);
        check_eq("R8", "miss", match, 0);
        send_byte(8'h4A);
        check_eq("R8", "byte after miss", match, 0);
        pulse_stop();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule